// File: doc/BRIEF.md
# Dialer Key Sequence Controller

This block is the sequencing core of a telephone dialer. It takes decoded key events and the hook state, and turns them into an ordered stream of commands for the dialing engines downstream. Each command is a digit, a pause or a line flash, and each carries a flag that says whether it is sent as tone or as pulse. Inside the block sit a command queue, a recording of the current call's keys for redial, a tone latch, and two hold timers. The timers count clock ticks; the integrator scales them to the wanted milliseconds.

One key does two jobs. As the first key after the line goes off-hook, it replays the recorded call. Later in the call, it inserts a pause. A star key pressed in pulse mode moves the rest of the call to tone. Flash keys take priority over everything: they discard queued work and then put the controller back in its starting condition. A lock setting refuses calls that begin with 0 (and, in one setting, also 9). The same lock setting holds dialing back for a fixed time after the line goes off-hook.

Top module: `dial_seq_ctrl`

## Requirements
- R1: Key codes 0..9 (digits) and 11 (hash), pressed off-hook, each produce one command with kind 0 (digit) whose code equals the key code. Commands come out in the order the keys were pressed, with the tone flag equal to `tone_mode` at the time of the press.
- R2: Key code 12 (redial/pause), when it is the first key after going off-hook, replays the recorded keys of the last call that had keys. The recording survives going on-hook.
- R3: Key code 12 pressed at any later point in a call produces a command with kind 1 (pause), code 0, and tone flag equal to the current mode. The pause is recorded and is replayed as a pause.
- R4: A call of up to RDEPTH recorded keys (32 by default) is replayed in full. Once a call records more than RDEPTH keys, redial on the next call produces no command.
- R5: Key code 10 (star/tone) in tone mode gives a digit command with code 10 and tone flag 1. In pulse mode it gives a pause with tone flag 0 when `star_alt` is 0, or a digit with code 10 and tone flag 1 when `star_alt` is 1. In every case, later digits carry tone flag 1.
- R6: `tone_mode` equals `!pulse_sel` or the tone latch. Once the latch is set, it stays set until the line goes on-hook, which clears it.
- R7: Key codes 16..19 drop every pending command and emit one command with kind 2 (flash) and code 0..3. For FLASH_GAP cycles after that, all keys are ignored. After the gap, the next key is treated as the first key of a call. Flash keys are never recorded.
- R8: With `lock_cfg` = 1, a first key of 0 or 9 after going off-hook is dropped, and so is every later key until on-hook. With `lock_cfg` = 2, only 0 triggers this. With `lock_cfg` = 0 there is no lock.
- R9: With `lock_cfg` nonzero, `dp_hold` is high for OFFHOOK_DLY cycles after going off-hook. Commands queued during that time are held back until it ends.
- R10: While `on_hook` is high, keys are ignored and the pending commands are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| on_hook | input | 1 | 1 = handset on-hook |
| pulse_sel | input | 1 | 1 = pulse dialing selected, 0 = tone |
| star_alt | input | 1 | Star key in pulse mode sends tone star instead of a pause |
| lock_cfg | input | 2 | 0 none, 1 lock on 0 or 9, 2 lock on 0 |
| key_valid | input | 1 | One-cycle strobe for a decoded key |
| key_code | input | 5 | Decoded key code |
| cmd_ready | input | 1 | Dialing engines accept the head command |
| cmd_valid | output | 1 | A command is offered |
| cmd_kind | output | 2 | 0 digit, 1 pause, 2 flash |
| cmd_code | output | 4 | Digit/symbol code or flash index |
| cmd_tone | output | 1 | 1 = send as tone |
| tone_mode | output | 1 | Current dialing mode is tone |
| dp_hold | output | 1 | Dial output held low (off-hook delay) |

## Verification
The main function is driven with three kinds of key pattern. Plain digit runs check ordering and the tone flag. Runs that mix pauses with hash are then redialled, which separates first-key redial from mid-call pause. Star presses in each mode and variant setting show whether the pause-then-tone switch or the tone star is taken, and that the latch persists. Flash and on-hook are issued with `cmd_ready` held low so that flushed commands would show up if they leaked. Calls of exactly 32 and of 33 keys bracket the redial limit. The lock settings are each tried with 0 and 9 as first keys, which separates the two lockout variants.

// File: rtl/dial_pkg.sv
package dial_pkg;

    localparam int KEY_W  = 5;
    localparam int CODE_W = 4;

    localparam logic [KEY_W-1:0]  KEY_STAR = 5'd10;
    localparam logic [KEY_W-1:0]  KEY_HASH = 5'd11;
    localparam logic [KEY_W-1:0]  KEY_RP   = 5'd12;
    localparam logic [CODE_W-1:0] SYM_STAR  = 4'd10;
    localparam logic [CODE_W-1:0] SYM_PAUSE = 4'd12;

    localparam logic [1:0] LOCK_OFF       = 2'd0;
    localparam logic [1:0] LOCK_ZERO_NINE = 2'd1;
    localparam logic [1:0] LOCK_ZERO      = 2'd2;

    typedef enum logic [1:0] {
        CMD_DIGIT = 2'd0,
        CMD_PAUSE = 2'd1,
        CMD_FLASH = 2'd2
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e          kind;
        logic [CODE_W-1:0]  code;
        logic               tone;
    } dial_cmd_t;

    typedef enum logic [1:0] {
        ST_READY,
        ST_REPLAY,
        ST_FLASH,
        ST_LOCKED
    } ctrl_state_e;

    // Map a recordable symbol to the command it produces in the current mode.
    function automatic dial_cmd_t sym_to_cmd(input logic [CODE_W-1:0] sym,
                                             input logic tone_now,
                                             input logic star_alt);
        dial_cmd_t c;
        c.kind = CMD_DIGIT;
        c.code = sym;
        c.tone = tone_now;
        if (sym == SYM_PAUSE) begin
            c.kind = CMD_PAUSE;
            c.code = '0;
        end else if (sym == SYM_STAR && !tone_now) begin
            if (star_alt) begin
                c.tone = 1'b1;
            end else begin
                c.kind = CMD_PAUSE;
                c.code = '0;
                c.tone = 1'b0;
            end
        end
        return c;
    endfunction

    function automatic logic lock_hit(input logic [KEY_W-1:0] key, input logic [1:0] cfg);
        case (cfg)
            LOCK_ZERO_NINE: return (key == 5'd0) || (key == 5'd9);
            LOCK_ZERO:      return key == 5'd0;
            default:        return 1'b0;
        endcase
    endfunction

    function automatic logic is_flash_key(input logic [KEY_W-1:0] key);
        return key[4:2] == 3'b100;
    endfunction

    function automatic logic is_dial_key(input logic [KEY_W-1:0] key);
        return key <= KEY_HASH;
    endfunction

endpackage

// File: rtl/dial_cmd_fifo.sv
module dial_cmd_fifo
    import dial_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      flush,
    input  logic      push,
    input  dial_cmd_t din,
    input  logic      pop,
    output dial_cmd_t dout,
    output logic      empty,
    output logic      full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    dial_cmd_t       mem [DEPTH];
    logic [AW-1:0]   wp;
    logic [AW-1:0]   rp;
    logic [CW-1:0]   cnt;
    logic            do_push;
    logic            do_pop;
    logic [AW-1:0]   waddr;

    assign do_push = push && (flush || !full);
    assign do_pop  = pop && !empty && !flush;
    assign waddr   = flush ? '0 : wp;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (flush) begin
            wp  <= push ? AW'(1) : '0;
            rp  <= '0;
            cnt <= push ? CW'(1) : '0;
        end else begin
            if (do_push) wp <= wp + AW'(1);
            if (do_pop)  rp <= rp + AW'(1);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[waddr] <= din;
    end

    assign dout  = mem[rp];
    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));

endmodule

// File: rtl/dial_redial_store.sv
module dial_redial_store
    import dial_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic                       wr,
    input  logic [CODE_W-1:0]          wr_code,
    input  logic [$clog2(DEPTH)-1:0]   rd_idx,
    output logic [CODE_W-1:0]          rd_code,
    output logic [$clog2(DEPTH+1)-1:0] len,
    output logic                       over
);
    localparam int IW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH + 1);

    logic [CODE_W-1:0] mem [DEPTH];
    logic              room;
    logic [IW-1:0]     waddr;

    assign room  = (len < LW'(DEPTH));
    assign waddr = clr ? '0 : len[IW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            len  <= '0;
            over <= 1'b0;
        end else if (clr) begin
            len  <= wr ? LW'(1) : '0;
            over <= 1'b0;
        end else if (wr) begin
            if (room) len  <= len + LW'(1);
            else      over <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr && (clr || room)) mem[waddr] <= wr_code;
    end

    assign rd_code = mem[rd_idx];

endmodule

// File: rtl/dial_hold_timer.sv
module dial_hold_timer #(
    parameter int LIMIT = 300
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic cancel,
    output logic busy
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || cancel)    cnt <= '0;
        else if (start)       cnt <= CW'(LIMIT);
        else if (cnt != '0)   cnt <= cnt - CW'(1);
    end

    assign busy = (cnt != '0);

endmodule

// File: rtl/dial_seq_ctrl.sv
module dial_seq_ctrl
    import dial_pkg::*;
#(
    parameter int QDEPTH      = 16,
    parameter int RDEPTH      = 32,
    parameter int OFFHOOK_DLY = 300,
    parameter int FLASH_GAP   = 1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        on_hook,
    input  logic        pulse_sel,
    input  logic        star_alt,
    input  logic [1:0]  lock_cfg,
    input  logic        key_valid,
    input  logic [4:0]  key_code,
    input  logic        cmd_ready,
    output logic        cmd_valid,
    output logic [1:0]  cmd_kind,
    output logic [3:0]  cmd_code,
    output logic        cmd_tone,
    output logic        tone_mode,
    output logic        dp_hold
);
    localparam int IW = $clog2(RDEPTH);
    localparam int LW = $clog2(RDEPTH + 1);

    ctrl_state_e       state, nxt_state;
    logic              first_key, nxt_first;
    logic [LW-1:0]     ptr, nxt_ptr;
    logic              tone_latch;
    logic              hook_q;

    logic              off_edge;
    logic              tone_now;
    logic              redial_ok;
    logic              flash_req;

    logic              q_push, q_flush, q_pop, q_empty, q_full;
    dial_cmd_t         q_din, q_head;

    logic              rec_clr, rec_wr;
    logic [CODE_W-1:0] rec_code, rec_rd;
    logic [LW-1:0]     rec_len;
    logic              rec_over;

    logic              set_latch;
    logic              fl_start, fl_busy;
    logic              hold_start;

    assign off_edge   = hook_q && !on_hook;
    assign tone_now   = !pulse_sel || tone_latch;
    assign redial_ok  = (rec_len != '0) && !rec_over;
    assign flash_req  = key_valid && is_flash_key(key_code) &&
                        (state == ST_READY || state == ST_REPLAY);
    assign hold_start = off_edge && (lock_cfg != LOCK_OFF);

    always_comb begin
        nxt_state = state;
        nxt_first = first_key;
        nxt_ptr   = ptr;
        q_push    = 1'b0;
        q_flush   = on_hook;
        q_din     = sym_to_cmd(key_code[3:0], tone_now, star_alt);
        rec_clr   = 1'b0;
        rec_wr    = 1'b0;
        rec_code  = key_code[3:0];
        set_latch = 1'b0;
        fl_start  = 1'b0;

        if (on_hook) begin
            nxt_state = ST_READY;
            nxt_first = 1'b1;
        end else if (flash_req) begin
            q_flush    = 1'b1;
            q_push     = 1'b1;
            q_din.kind = CMD_FLASH;
            q_din.code = {2'b00, key_code[1:0]};
            q_din.tone = tone_now;
            fl_start   = 1'b1;
            nxt_state  = ST_FLASH;
            nxt_first  = 1'b0;
        end else begin
            case (state)
                ST_READY: begin
                    if (key_valid) begin
                        if (first_key && lock_hit(key_code, lock_cfg)) begin
                            nxt_state = ST_LOCKED;
                            nxt_first = 1'b0;
                        end else if (key_code == KEY_RP) begin
                            nxt_first = 1'b0;
                            if (first_key) begin
                                if (redial_ok) begin
                                    nxt_state = ST_REPLAY;
                                    nxt_ptr   = '0;
                                end
                            end else begin
                                q_push = 1'b1;
                                rec_wr = 1'b1;
                            end
                        end else if (is_dial_key(key_code)) begin
                            q_push    = 1'b1;
                            rec_wr    = 1'b1;
                            rec_clr   = first_key;
                            set_latch = (key_code == KEY_STAR);
                            nxt_first = 1'b0;
                        end
                    end
                end
                ST_REPLAY: begin
                    if (!q_full) begin
                        q_push    = 1'b1;
                        q_din     = sym_to_cmd(rec_rd, tone_now, star_alt);
                        set_latch = (rec_rd == SYM_STAR);
                        nxt_ptr   = ptr + LW'(1);
                        if ((ptr + LW'(1)) == rec_len) nxt_state = ST_READY;
                    end
                end
                ST_FLASH: begin
                    if (!fl_busy) begin
                        nxt_state = ST_READY;
                        nxt_first = 1'b1;
                    end
                end
                default: begin
                    nxt_state = ST_LOCKED;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_READY;
            first_key  <= 1'b1;
            ptr        <= '0;
            tone_latch <= 1'b0;
            hook_q     <= 1'b1;
        end else begin
            state     <= nxt_state;
            first_key <= nxt_first;
            ptr       <= nxt_ptr;
            hook_q    <= on_hook;
            if (on_hook)        tone_latch <= 1'b0;
            else if (set_latch) tone_latch <= 1'b1;
        end
    end

    dial_cmd_fifo #(.DEPTH(QDEPTH)) u_queue (
        .clk   (clk),
        .rst   (rst),
        .flush (q_flush),
        .push  (q_push),
        .din   (q_din),
        .pop   (q_pop),
        .dout  (q_head),
        .empty (q_empty),
        .full  (q_full)
    );

    dial_redial_store #(.DEPTH(RDEPTH)) u_recall (
        .clk     (clk),
        .rst     (rst),
        .clr     (rec_clr),
        .wr      (rec_wr),
        .wr_code (rec_code),
        .rd_idx  (ptr[IW-1:0]),
        .rd_code (rec_rd),
        .len     (rec_len),
        .over    (rec_over)
    );

    dial_hold_timer #(.LIMIT(OFFHOOK_DLY)) u_offhook (
        .clk    (clk),
        .rst    (rst),
        .start  (hold_start),
        .cancel (on_hook),
        .busy   (dp_hold)
    );

    dial_hold_timer #(.LIMIT(FLASH_GAP)) u_flashgap (
        .clk    (clk),
        .rst    (rst),
        .start  (fl_start),
        .cancel (on_hook),
        .busy   (fl_busy)
    );

    assign cmd_valid = !q_empty && !dp_hold;
    assign q_pop     = cmd_valid && cmd_ready;
    assign cmd_kind  = q_head.kind;
    assign cmd_code  = q_head.code;
    assign cmd_tone  = q_head.tone;
    assign tone_mode = tone_now;

endmodule

// File: rtl/dial_seq_chk.sv
module dial_seq_chk
    import dial_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        on_hook,
    input logic        pulse_sel,
    input logic [1:0]  lock_cfg,
    input logic        cmd_valid,
    input logic        tone_mode,
    input logic        dp_hold,
    input ctrl_state_e state
);

    // R10
    onhook_flush_chk: assert property (@(posedge clk) disable iff (rst)
        on_hook |=> !cmd_valid);

    // R6
    tone_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (tone_mode && !on_hook) |=> (tone_mode || !$stable(pulse_sel)));

    // R6
    tone_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(on_hook) && pulse_sel) |-> !tone_mode);

    // R8
    lock_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOCKED && !on_hook) |=> (state == ST_LOCKED));

    // R9
    hold_start_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(on_hook) && lock_cfg != LOCK_OFF) |=> dp_hold);

endmodule

bind dial_seq_ctrl dial_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .on_hook   (on_hook),
    .pulse_sel (pulse_sel),
    .lock_cfg  (lock_cfg),
    .cmd_valid (cmd_valid),
    .tone_mode (tone_mode),
    .dp_hold   (dp_hold),
    .state     (state)
);

// File: tb/tb_dial_seq_ctrl.sv
module tb_dial_seq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DLY = 20;
    localparam int GAP = 30;
    localparam logic [1:0] K_DIG = 2'd0, K_PAU = 2'd1, K_FL = 2'd2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic on_hook = 1'b1, pulse_sel = 1'b1, star_alt = 1'b0;
    logic [1:0] lock_cfg = 2'd0;
    logic key_valid = 1'b0;
    logic [4:0] key_code = '0;
    logic cmd_ready = 1'b1;
    logic cmd_valid, cmd_tone, tone_mode, dp_hold;
    logic [1:0] cmd_kind;
    logic [3:0] cmd_code;

    int errors = 0;
    int checks = 0;
    string cur_req = "R10";
    logic [6:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dial_seq_ctrl #(.QDEPTH(16), .RDEPTH(32), .OFFHOOK_DLY(DLY), .FLASH_GAP(GAP)) dut (
        .clk(clk), .rst(rst), .on_hook(on_hook), .pulse_sel(pulse_sel), .star_alt(star_alt),
        .lock_cfg(lock_cfg), .key_valid(key_valid), .key_code(key_code), .cmd_ready(cmd_ready),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_code(cmd_code), .cmd_tone(cmd_tone),
        .tone_mode(tone_mode), .dp_hold(dp_hold)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic press(input int c);
        step();
        key_valid = 1'b1;
        key_code  = 5'(c);
        step();
        key_valid = 1'b0;
    endtask

    task automatic ex(input logic [1:0] k, input int c, input bit t);
        exp_q.push_back({k, 4'(c), t});
    endtask

    task automatic go_off();
        step();
        on_hook = 1'b0;
        repeat (3) step();
    endtask

    task automatic go_on();
        step();
        on_hook = 1'b1;
        repeat (4) step();
    endtask

    task automatic drain();
        for (int n = 0; n < 3000 && exp_q.size() != 0; n++) @(negedge clk);
        repeat (6) @(negedge clk);
        chk(exp_q.size() == 0, cur_req, exp_q.size(), 0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Monitor: compare every accepted command with the scoreboard head
    always @(negedge clk) begin
        if (!rst && cmd_valid && cmd_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, cur_req, int'({cmd_kind, cmd_code, cmd_tone}), -1);
            end else begin
                logic [6:0] e;
                e = exp_q.pop_front();
                chk({cmd_kind, cmd_code, cmd_tone} == e, cur_req,
                    int'({cmd_kind, cmd_code, cmd_tone}), int'(e));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (4) step();
        rst = 1'b0;
        step();
        // Reset state (R10, R9, R6)
        chk(cmd_valid == 1'b0, "R10", cmd_valid, 0);
        chk(dp_hold == 1'b0, "R9", dp_hold, 0);
        chk(tone_mode == 1'b0, "R6", tone_mode, 0);

        // R1 / R3: digits, hash and a mid-call pause in pulse mode
        cur_req = "R1";
        go_off();
        ex(K_DIG, 5, 0); press(5);
        ex(K_DIG, 1, 0); press(1);
        ex(K_DIG, 11, 0); press(11);
        cur_req = "R3";
        ex(K_PAU, 0, 0); press(12);
        ex(K_DIG, 7, 0); press(7);
        drain();
        go_on();

        // R2: first-key redial replays, pause included
        cur_req = "R2";
        go_off();
        ex(K_DIG, 5, 0); ex(K_DIG, 1, 0); ex(K_DIG, 11, 0); ex(K_PAU, 0, 0); ex(K_DIG, 7, 0);
        press(12);
        drain();
        go_on();

        // R5 / R6: star in pulse mode -> pause then tone
        cur_req = "R5";
        go_off();
        ex(K_DIG, 2, 0); press(2);
        ex(K_PAU, 0, 0); press(10);
        ex(K_DIG, 6, 1); press(6);
        ex(K_DIG, 10, 1); press(10);
        drain();
        chk(tone_mode == 1'b1, "R6", tone_mode, 1);
        go_on();
        chk(tone_mode == 1'b0, "R6", tone_mode, 0);

        // R10: keys while on-hook are ignored
        cur_req = "R10";
        press(4);
        repeat (8) step();
        chk(cmd_valid == 1'b0, "R10", cmd_valid, 0);

        // R5: variant sends tone star
        cur_req = "R5";
        star_alt = 1'b1;
        go_off();
        ex(K_DIG, 8, 0); press(8);
        ex(K_DIG, 10, 1); press(10);
        ex(K_DIG, 1, 1); press(1);
        drain();
        go_on();
        star_alt = 1'b0;

        // R5 / R1: tone mode selected by the mode input
        pulse_sel = 1'b0;
        go_off();
        ex(K_DIG, 4, 1); press(4);
        ex(K_DIG, 10, 1); press(10);
        drain();
        go_on();
        pulse_sel = 1'b1;

        // R7: flash drops pending work, ignores keys in the gap, then first-key again
        cur_req = "R7";
        cmd_ready = 1'b0;
        go_off();
        press(1); press(2);
        press(17);
        ex(K_FL, 1, 0);
        step();
        cmd_ready = 1'b1;
        press(3);
        repeat (GAP + 5) step();
        chk(exp_q.size() == 0, "R7", exp_q.size(), 0);
        ex(K_DIG, 1, 0); ex(K_DIG, 2, 0);
        press(12);
        drain();

        // R10: on-hook discards queued commands
        cur_req = "R10";
        cmd_ready = 1'b0;
        press(3); press(4);
        go_on();
        cmd_ready = 1'b1;
        repeat (8) step();
        chk(cmd_valid == 1'b0, "R10", cmd_valid, 0);
        drain();

        // R4: 32-key call replays in full
        cur_req = "R4";
        go_off();
        for (int i = 0; i < 32; i++) begin
            ex(K_DIG, (i + 3) % 10, 0);
            press((i + 3) % 10);
        end
        drain();
        go_on();
        go_off();
        for (int i = 0; i < 32; i++) ex(K_DIG, (i + 3) % 10, 0);
        press(12);
        drain();
        go_on();

        // R4: 33-key call disables redial
        go_off();
        for (int i = 0; i < 33; i++) begin
            ex(K_DIG, (i + 1) % 10, 0);
            press((i + 1) % 10);
        end
        drain();
        go_on();
        go_off();
        press(12);
        repeat (40) step();
        chk(cmd_valid == 1'b0, "R4", cmd_valid, 0);
        drain();
        go_on();

        // R9: off-hook delay with lock enabled
        cur_req = "R9";
        lock_cfg = 2'd1;
        go_off();
        chk(dp_hold == 1'b1, "R9", dp_hold, 1);
        ex(K_DIG, 5, 0); press(5);
        repeat (2) step();
        chk(cmd_valid == 1'b0, "R9", cmd_valid, 0);
        repeat (DLY + 2) step();
        chk(dp_hold == 1'b0, "R9", dp_hold, 0);
        drain();
        go_on();

        // R8: lock on 9 as first key, later keys and flash dropped
        cur_req = "R8";
        go_off();
        repeat (DLY + 2) step();
        press(9); press(5); press(16); press(3);
        repeat (20) step();
        chk(cmd_valid == 1'b0, "R8", cmd_valid, 0);
        drain();
        go_on();

        // R8: zero-only lock lets 9 through, blocks 0
        lock_cfg = 2'd2;
        go_off();
        repeat (DLY + 2) step();
        ex(K_DIG, 9, 0); press(9);
        drain();
        go_on();
        go_off();
        repeat (DLY + 2) step();
        press(0); press(3);
        repeat (20) step();
        chk(cmd_valid == 1'b0, "R8", cmd_valid, 0);
        drain();
        go_on();

        finish_run();
    end

endmodule